// File: doc/BRIEF.md
# Banked Interrupt Controller

This block collects up to 64 interrupt sources into two banks of 32 and drives one interrupt line to the CPU. Each bank exposes a small group of word registers on a simple register bus:

- a latched event register;
- an enable register;
- a write-one-to-clear acknowledge register;
- a raw input level register.

A constant mask, set per bank at build time, makes a source level-sensitive. A level-sensitive source requests service for as long as its input is high and it is enabled. Every other source is edge-sensitive: a rising edge is latched as an event and stays latched until software acknowledges it.

Software finds the source to serve by reading the registers. It clears an edge event by writing a one to the matching acknowledge bit. It reads the level register to see the live input state. A side output names the highest-numbered pending source; it exists to help with checking.

Enabling an edge source whose input is already high does not create an event. Only an edge seen while the source is enabled is latched.

Top module: `irqc_top`

## Requirements
- R1: Bank b sits at byte offset 0x20 - 0x10*b, so bank 0 (sources 0..31) is at 0x20 and bank 1 (sources 32..63) at 0x10. Within a bank the event register is at +0x0, enable at +0x4, acknowledge at +0x8 and level at +0xC. Source n lives in bank n>>5 at bit n&31, and src_in bit n carries source n.
- R2: An edge-sensitive source whose enable bit is set latches its event bit on a rising edge of its input, after a two-flop synchronizer. The bit stays set until it is acknowledged.
- R3: A write to the acknowledge register clears each event bit written as 1 and leaves bits written as 0 unchanged. If a new edge and an acknowledge of the same bit meet in one cycle, the bit ends up set.
- R4: Setting an enable bit while that edge source's input is already high neither sets its event bit nor raises cpu_irq.
- R5: The level register returns the synchronized raw state of every source of the bank, whether or not the source is enabled.
- R6: Sources whose bit is set in LEVEL_MASK are level-sensitive, and their event bits always read 0. By default this is bank 0 bits 20..28 (0x1FF00000) and no bits in bank 1. Such a source is pending exactly while its input is high and it is enabled.
- R7: After reset every enable register reads 0, and an enable register reads back the value last written to it.
- R8: A source is pending when (event OR (level AND mask)) AND enable has its bit set. cpu_irq is a register that is high one cycle after any source is pending and low one cycle after none is.
- R9: top_valid is high while any source is pending, and top_id then gives the number of the highest-numbered pending source.
- R10: Read data appears on bus_rdata in the cycle after the read request. The acknowledge register reads as 0. Misaligned or unmapped offsets read as 0. Writes to the event register, the level register or unmapped offsets change nothing.
- R11: After reset all event and enable bits are 0, cpu_irq and top_valid are low, and bus_rdata is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_in | input | 64 | Asynchronous interrupt source inputs, bit n is source n |
| bus_valid | input | 1 | Register access request this cycle |
| bus_write | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after a read request |
| cpu_irq | output | 1 | Combined interrupt request to the CPU |
| top_valid | output | 1 | Some source is pending |
| top_id | output | 6 | Highest-numbered pending source |

## Verification
A wrong event bit is caught on the next read of that bank's event register. If the source is enabled, it is caught one cycle earlier on cpu_irq and at once on top_id and top_valid. A wrong enable bit shows on its readback and in whether a raised input ever reaches cpu_irq. A wrong edge detector or synchronizer shows as an event that was missed or invented within about four cycles of an input change. The tightest timing point is the cycle in which an edge and an acknowledge meet, which the bench drives with exact cycle placement.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    localparam int BANK_W    = 32;
    localparam int BIT_IDX_W = 5;

    typedef enum logic [1:0] {
        REG_EVENT  = 2'd0,
        REG_ENABLE = 2'd1,
        REG_ACK    = 2'd2,
        REG_LEVEL  = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic              en_we;
        logic              ack_we;
        logic [BANK_W-1:0] wdata;
    } bank_cmd_t;

    typedef struct packed {
        logic [BANK_W-1:0] event_q;
        logic [BANK_W-1:0] enable_q;
        logic [BANK_W-1:0] level_q;
        logic [BANK_W-1:0] pending;
    } bank_view_t;

    function automatic logic [BIT_IDX_W-1:0] top_bit(input logic [BANK_W-1:0] v);
        logic [BIT_IDX_W-1:0] idx;
        idx = '0;
        for (int i = 0; i < BANK_W; i++) begin
            if (v[i]) idx = BIT_IDX_W'(i);
        end
        return idx;
    endfunction

endpackage

// File: rtl/irqc_sync.sv
module irqc_sync #(
    parameter int W = 64
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] meta_q;
    logic [W-1:0] stab_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= '0;
            stab_q <= '0;
        end else begin
            meta_q <= d_i;
            stab_q <= meta_q;
        end
    end

    assign q_o = stab_q;
endmodule

// File: rtl/irqc_bank.sv
module irqc_bank
    import irqc_pkg::*;
#(
    parameter logic [BANK_W-1:0] LMASK = 32'h0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [BANK_W-1:0] lvl_i,
    input  bank_cmd_t         cmd_i,
    output bank_view_t        view_o
);
    logic [BANK_W-1:0] prev_q;
    logic [BANK_W-1:0] event_q;
    logic [BANK_W-1:0] enable_q;
    logic [BANK_W-1:0] set_vec;
    logic [BANK_W-1:0] clr_vec;
    logic [BANK_W-1:0] event_d;

    // edge sources only, and only while enabled
    assign set_vec = lvl_i & ~prev_q & ~LMASK & enable_q;
    assign clr_vec = cmd_i.ack_we ? cmd_i.wdata : '0;
    assign event_d = (event_q & ~clr_vec) | set_vec;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q   <= '0;
            event_q  <= '0;
            enable_q <= '0;
        end else begin
            prev_q  <= lvl_i;
            event_q <= event_d;
            if (cmd_i.en_we) enable_q <= cmd_i.wdata;
        end
    end

    assign view_o.event_q  = event_q;
    assign view_o.enable_q = enable_q;
    assign view_o.level_q  = lvl_i;
    assign view_o.pending  = (event_q | (lvl_i & LMASK)) & enable_q;

    // R3: acknowledged bits are clear next cycle unless a new edge arrived
    a_r3_ack_clears: assert property (@(posedge clk) disable iff (rst)
        cmd_i.ack_we |=> ((event_q & $past(cmd_i.wdata) & ~$past(set_vec)) == '0));

    // R7: enable reads back what was written
    a_r7_enable_readback: assert property (@(posedge clk) disable iff (rst)
        cmd_i.en_we |=> (enable_q == $past(cmd_i.wdata)));

    // R2 / R4: an event bit only rises after a new input edge seen while enabled
    a_r4_no_event_without_edge: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((event_q & ~$past(event_q) &
                   ~($past(lvl_i) & ~$past(prev_q) & $past(enable_q))) == '0));

    // R6: level-sensitive sources never hold a latched event
    a_r6_level_no_event: assert property (@(posedge clk) disable iff (rst)
        ((event_q & LMASK) == '0));
endmodule

// File: rtl/irqc_top.sv
module irqc_top
    import irqc_pkg::*;
#(
    parameter int                          NUM_BANKS  = 2,
    parameter int                          ADDR_W     = 8,
    parameter logic [NUM_BANKS*BANK_W-1:0] LEVEL_MASK = 64'h0000_0000_1FF0_0000
) (
    input  logic                               clk,
    input  logic                               rst,
    input  logic [NUM_BANKS*BANK_W-1:0]        src_in,
    input  logic                               bus_valid,
    input  logic                               bus_write,
    input  logic [ADDR_W-1:0]                  bus_addr,
    input  logic [BANK_W-1:0]                  bus_wdata,
    output logic [BANK_W-1:0]                  bus_rdata,
    output logic                               cpu_irq,
    output logic                               top_valid,
    output logic [$clog2(NUM_BANKS*BANK_W)-1:0] top_id
);
    localparam int NSRC = NUM_BANKS * BANK_W;
    localparam int ID_W = $clog2(NSRC);
    localparam int BF_W = ADDR_W - 4;

    logic [NSRC-1:0]      lvl_sync;
    bank_view_t           views    [NUM_BANKS];
    logic [NUM_BANKS-1:0] bank_hit;
    logic [NUM_BANKS-1:0] ev_en;
    reg_sel_e             reg_sel;
    logic                 aligned;
    logic                 any_hit;
    logic [BANK_W-1:0]    rd_d;
    logic                 top_valid_c;
    logic [ID_W-1:0]      top_id_c;

    irqc_sync #(.W(NSRC)) u_sync (
        .clk (clk),
        .rst (rst),
        .d_i (src_in),
        .q_o (lvl_sync)
    );

    assign reg_sel = reg_sel_e'(bus_addr[3:2]);
    assign aligned = (bus_addr[1:0] == 2'b00);

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        bank_cmd_t cmd;

        // banks are placed at descending addresses
        assign bank_hit[b] = bus_valid && aligned &&
                             (bus_addr[ADDR_W-1:4] == BF_W'(NUM_BANKS - b));
        assign cmd.en_we   = bank_hit[b] && bus_write && (reg_sel == REG_ENABLE);
        assign cmd.ack_we  = bank_hit[b] && bus_write && (reg_sel == REG_ACK);
        assign cmd.wdata   = bus_wdata;
        assign ev_en[b]    = |(views[b].event_q & views[b].enable_q);

        irqc_bank #(.LMASK(LEVEL_MASK[b*BANK_W +: BANK_W])) u_bank (
            .clk    (clk),
            .rst    (rst),
            .lvl_i  (lvl_sync[b*BANK_W +: BANK_W]),
            .cmd_i  (cmd),
            .view_o (views[b])
        );
    end

    always_comb begin
        rd_d    = '0;
        any_hit = 1'b0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (bank_hit[b]) begin
                any_hit = 1'b1;
                unique case (reg_sel)
                    REG_EVENT:  rd_d = views[b].event_q;
                    REG_ENABLE: rd_d = views[b].enable_q;
                    REG_ACK:    rd_d = '0;
                    REG_LEVEL:  rd_d = views[b].level_q;
                endcase
            end
        end
    end

    always_comb begin
        top_valid_c = 1'b0;
        top_id_c    = '0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (|views[b].pending) begin
                top_valid_c = 1'b1;
                top_id_c    = ID_W'(b * BANK_W) | ID_W'(top_bit(views[b].pending));
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bus_rdata <= '0;
            cpu_irq   <= 1'b0;
        end else begin
            if (bus_valid && !bus_write) bus_rdata <= rd_d;
            cpu_irq <= top_valid_c;
        end
    end

    assign top_valid = top_valid_c;
    assign top_id    = top_id_c;

    // R10: unmapped or misaligned reads return zero
    a_r10_unmapped_zero: assert property (@(posedge clk) disable iff (rst)
        (bus_valid && !bus_write && !any_hit) |=> (bus_rdata == '0));

    // R8: an enabled latched event in any bank raises cpu_irq next cycle
    a_r8_event_raises_irq: assert property (@(posedge clk) disable iff (rst)
        (|ev_en) |=> cpu_irq);

    // R9: selected source is pending in its bank
    a_r9_top_is_pending: assert property (@(posedge clk) disable iff (rst)
        top_valid |-> views[top_id[ID_W-1:5]].pending[top_id[4:0]]);
endmodule

// File: tb/irqc_top_bench.sv
module irqc_top_bench;
    localparam int          CLK_PERIOD = 10;
    localparam logic [63:0] LMASK      = 64'h0000_0000_1FF0_0000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [63:0] src_in = '0;
    logic        bus_valid = 1'b0;
    logic        bus_write = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        cpu_irq;
    logic        top_valid;
    logic [5:0]  top_id;

    int n_vec = 0;
    int n_bad = 0;
    logic [63:0] m_in = '0;
    logic [63:0] m_ev = '0;
    logic [63:0] m_en = '0;

    irqc_top u_irqc_top (
        .clk       (clk),
        .rst       (rst),
        .src_in    (src_in),
        .bus_valid (bus_valid),
        .bus_write (bus_write),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .cpu_irq   (cpu_irq),
        .top_valid (top_valid),
        .top_id    (top_id)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL R11 watchdog: act=running exp=finished");
        summary();
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] addr_of(input int b, input int r);
        return 8'(((2 - b) << 4) | (r << 2));
    endfunction

    function automatic logic [63:0] exp_pend();
        return (m_ev | (m_in & LMASK)) & m_en;
    endfunction

    function automatic logic [5:0] exp_top(input logic [63:0] p);
        logic [5:0] id = '0;
        for (int i = 0; i < 64; i++) if (p[i]) id = 6'(i);
        return id;
    endfunction

    task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0;
    endtask

    task automatic bus_rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
        @(negedge clk);
        d = bus_rdata;
        bus_valid = 1'b0;
    endtask

    task automatic settle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // R2 model: enabled edge sources latch on rising inputs
    task automatic set_inputs(input logic [63:0] v);
        m_ev = m_ev | (v & ~m_in & ~LMASK & m_en);
        m_in = v;
        @(negedge clk);
        src_in = v;
        settle(5);
    endtask

    task automatic wr_enable(input int b, input logic [31:0] v);
        bus_wr(addr_of(b, 1), v);
        m_en[b*32 +: 32] = v;
        settle(3);
    endtask

    task automatic wr_ack(input int b, input logic [31:0] v);
        bus_wr(addr_of(b, 2), v);
        m_ev[b*32 +: 32] = m_ev[b*32 +: 32] & ~v;
        settle(3);
    endtask

    task automatic check_all(input string req);
        logic [31:0] d;
        logic [63:0] p;
        for (int b = 0; b < 2; b++) begin
            bus_rd(addr_of(b, 0), d); chk({req, " R1 event"},  d, m_ev[b*32 +: 32]);
            bus_rd(addr_of(b, 1), d); chk({req, " R7 enable"}, d, m_en[b*32 +: 32]);
            bus_rd(addr_of(b, 2), d); chk({req, " R10 ack"},   d, 32'h0);
            bus_rd(addr_of(b, 3), d); chk({req, " R5 level"},  d, m_in[b*32 +: 32]);
        end
        settle(2);
        p = exp_pend();
        chk({req, " R8 cpu_irq"},   32'(cpu_irq),   32'(|p));
        chk({req, " R9 top_valid"}, 32'(top_valid), 32'(|p));
        if (|p) chk({req, " R9 top_id"}, 32'(top_id), 32'(exp_top(p)));
    endtask

    initial begin
        logic [31:0] d;
        logic [31:0] seed_use;
        seed_use = $urandom(32'd20250611);

        // R11: reset state
        repeat (3) @(negedge clk);
        rst = 1'b0;
        chk("R11 cpu_irq", 32'(cpu_irq), 32'h0);
        chk("R11 top_valid", 32'(top_valid), 32'h0);
        chk("R11 rdata", bus_rdata, 32'h0);
        check_all("R11");

        // R7 readback, R10 unmapped and misaligned
        wr_enable(1, 32'hA5A5_0000);
        wr_enable(1, 32'h0);
        bus_rd(8'h00, d); chk("R10 unmapped 0x00", d, 32'h0);
        bus_rd(8'h34, d); chk("R10 unmapped 0x34", d, 32'h0);
        bus_rd(8'h25, d); chk("R10 misaligned", d, 32'h0);

        // R2, R8, R9: edge on source 3
        wr_enable(0, 32'h0000_0008);
        set_inputs(64'h8);
        check_all("R2");

        // R3: zero ack ignored, then clear
        wr_ack(0, 32'h0);
        check_all("R3 zero");
        wr_ack(0, 32'h8);
        check_all("R3 clear");

        // R4: source 40 high before enable
        set_inputs(64'h0000_0100_0000_0000);
        wr_enable(1, 32'h0000_0100);
        check_all("R4");

        // R6: level source 22
        wr_enable(0, 32'h0040_0008);
        set_inputs(64'h0000_0100_0040_0000);
        check_all("R6 high");
        set_inputs(64'h0000_0100_0000_0000);
        check_all("R6 low");

        // R10: writes to event, level and unmapped ignored
        set_inputs(64'h0000_0000_0000_0008);
        bus_wr(addr_of(0, 0), 32'h0);
        bus_wr(addr_of(0, 3), 32'hFFFF_FFFF);
        bus_wr(8'h04, 32'hFFFF_FFFF);
        check_all("R10 ro");

        // R9: two events in different banks, highest wins
        set_inputs(64'h0);
        set_inputs(64'h0000_0100_0000_0000);
        check_all("R9 two");
        wr_ack(0, 32'hFFFF_FFFF);
        wr_ack(1, 32'hFFFF_FFFF);
        set_inputs(64'h0);

        // R3: edge and ack on source 5 in the same cycle, set wins
        wr_enable(0, 32'h0000_0020);
        @(negedge clk);
        src_in = 64'h20;
        @(negedge clk);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = addr_of(0, 2); bus_wdata = 32'h20;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0;
        m_in = 64'h20;
        m_ev[5] = 1'b1;
        settle(3);
        check_all("R3 race");

        // random mix
        for (int it = 0; it < 80; it++) begin
            int op;
            op = int'($urandom % 3);
            if (op == 0) set_inputs({$urandom, $urandom});
            else if (op == 1) wr_enable(int'($urandom % 2), $urandom);
            else wr_ack(int'($urandom % 2), $urandom);
            check_all("R8 rand");
        end

        summary();
    end
endmodule